// File: doc/BRIEF.md
# Match Output Level and PWM Driver

This block turns per-channel match events from a timer into output levels. Each channel has one stored level bit. A 2-bit action code decides what happens to that bit when the channel's match pulse arrives: the bit can be held, cleared, set or toggled. Software can read the stored levels and overwrite them through a register write. A write of the same register also loads the action codes.

A separate per-channel mode bit hands the output over to a pulse-width generator. In that mode the output comes from comparing the running timer count with the channel's match value. The output is low below the match value and high from the match value until the period restarts. The highest channel is normally used to set the period and to reset the counter.

The block does not count, detect matches or multiplex pins. It receives the match pulses, the count and the match values from the surrounding timer.

Top module: `match_out_driver`

## Requirements
- R1: After a synchronous active-low reset, all stored levels (`em_level`), all outputs (`mat_out`), all action codes and all PWM mode bits are zero.
- R2: A cycle with `emr_wr` high and no active match action on a channel loads `emr_wdata[n]` into level n at that clock edge. In match mode `mat_out[n]` equals `em_level[n]` from that point on.
- R3: Action code 01 (action field n at `emr_wdata[NCH+2n+1:NCH+2n]`) forces level n to 0 at the clock edge where `match_hit[n]` is high.
- R4: Action code 10 forces level n to 1 at the clock edge where `match_hit[n]` is high.
- R5: Action code 11 inverts level n at every clock edge where `match_hit[n]` is high, including on consecutive cycles.
- R6: Action code 00 leaves level n unchanged when `match_hit[n]` is high and no write is present.
- R7: When a write and a non-hold match action on channel n occur in the same cycle, the action decides level n. The action used is the code in effect before that write. The newly written code applies from the next cycle on.
- R8: When PWM mode bit n is 1 (loaded from `pwm_wdata[n]` on `pwm_wr`, effective the next cycle), `mat_out[n]` is 1 exactly when the `tc_val` sampled at the previous clock edge was greater than or equal to match value n (`match_val[TW*n +: TW]`). Otherwise it is 0.
- R9: Level bits continue to follow match actions and writes while their channel is in PWM mode. Leaving PWM mode shows the stored level on `mat_out[n]` from the next cycle on.
- R10: A match pulse, action code or mode bit on one channel has no effect on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| emr_wr | input | 1 | Write strobe for levels and action codes |
| emr_wdata | input | 3*NCH | Levels in [NCH-1:0], 2-bit action codes above them |
| pwm_wr | input | 1 | Write strobe for PWM mode bits |
| pwm_wdata | input | NCH | PWM mode bit per channel (1 = PWM) |
| match_hit | input | NCH | One-cycle match pulse per channel |
| tc_val | input | TW | Current timer count |
| match_val | input | NCH*TW | Match value per channel, channel n at [TW*n +: TW] |
| em_level | output | NCH | Stored level bits, for read-back |
| mat_out | output | NCH | Driven output level per channel |

## Verification
The bench targets a write and a match pulse landing in the same cycle, including a write that changes the action code at that moment. A design that lets the write win, or that applies the new code at once, leaves the wrong level. Back-to-back toggle pulses catch a design that only reacts to a rising edge of the pulse. PWM channels are driven with counts equal to, just below and just above the match value: an off-by-one compare puts the edge one count late or early. A design that freezes or drops level bits while a channel is in PWM mode shows the wrong output once the channel returns to match mode.

// File: rtl/mo_pkg.sv
// Package: shared types for the match output driver.
// Assumes: action codes are 2 bits, encoded as below.
package mo_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } mo_act_e;
endpackage

// File: rtl/mo_ctrl_regs.sv
// Module: mo_ctrl_regs
// Holds the per-channel action codes and PWM mode bits.
// Assumes: action field n sits at wdata[NCH+2n +: 2]; a write takes effect next cycle.
module mo_ctrl_regs #(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               emr_wr,
    input  logic [3*NCH-1:0]   emr_wdata,
    input  logic               pwm_wr,
    input  logic [NCH-1:0]     pwm_wdata,
    output logic [2*NCH-1:0]   act_codes,
    output logic [NCH-1:0]     pwm_sel
);
    localparam int ACT_LSB = NCH;

    // Action code storage, loaded from the upper write field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_codes <= '0;
        else if (emr_wr)
            act_codes <= emr_wdata[ACT_LSB +: 2*NCH];
    end

    // PWM mode bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_sel <= '0;
        else if (pwm_wr)
            pwm_sel <= pwm_wdata;
    end

    // R1: control state returns to zero after reset
    a_r1_ctrl_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> (act_codes == '0 && pwm_sel == '0));

    // R8: mode bits change only on a PWM write
    a_r8_mode_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwm_wr) && $past(rst_n) |-> $stable(pwm_sel));
endmodule

// File: rtl/mo_level_unit.sv
// Module: mo_level_unit
// Keeps one channel's stored level and applies its match action or a write.
// Assumes: the hit is a one-cycle pulse; a non-hold action beats a same-cycle write.
module mo_level_unit
    import mo_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit,
    input  mo_act_e act,
    input  logic    wr,
    input  logic    wbit,
    output logic    level
);
    logic nxt;
    logic act_live;

    // An action counts only when the pulse is present and the code is not hold.
    assign act_live = hit && (act != ACT_HOLD);

    // Choose the next level: action first, then write, else keep.
    always_comb begin
        nxt = level;
        if (act_live) begin
            case (act)
                ACT_LOW:  nxt = 1'b0;
                ACT_HIGH: nxt = 1'b1;
                ACT_FLIP: nxt = ~level;
                default:  nxt = level;
            endcase
        end else if (wr) begin
            nxt = wbit;
        end
    end

    // Level register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= 1'b0;
        else
            level <= nxt;
    end

    // R3: clear action drives the level low
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hit && act == ACT_LOW |=> !level);
    // R4: set action drives the level high
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit && act == ACT_HIGH |=> level);
    // R5: toggle action inverts the level
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        hit && act == ACT_FLIP |=> level != $past(level));
    // R6: hold action with no write keeps the level
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hit && act == ACT_HOLD && !wr |=> $stable(level));
    // R2: a write without an action loads the written bit
    a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !(hit && act != ACT_HOLD) |=> level == $past(wbit));
endmodule

// File: rtl/mo_pwm_cmp.sv
// Module: mo_pwm_cmp
// Registers the compare of the timer count against one match value.
// Assumes: output is high from the match value until the counter restarts.
module mo_pwm_cmp #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tc_val,
    input  logic [TW-1:0] mval,
    output logic          wave
);
    // Compare register, one cycle behind the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave <= 1'b0;
        else
            wave <= (tc_val >= mval);
    end

    // R8: a count of zero below a nonzero match gives a low wave next cycle
    a_r8_low_below: assert property (@(posedge clk) disable iff (!rst_n)
        tc_val == '0 && mval != '0 |=> !wave);
endmodule

// File: rtl/match_out_driver.sv
// Module: match_out_driver (top)
// Drives NCH match outputs from stored levels or from PWM compares.
// Assumes: match pulses, count and match values come from the timer core.
module match_out_driver
    import mo_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                emr_wr,
    input  logic [3*NCH-1:0]    emr_wdata,
    input  logic                pwm_wr,
    input  logic [NCH-1:0]      pwm_wdata,
    input  logic [NCH-1:0]      match_hit,
    input  logic [TW-1:0]       tc_val,
    input  logic [NCH*TW-1:0]   match_val,
    output logic [NCH-1:0]      em_level,
    output logic [NCH-1:0]      mat_out
);
    logic [2*NCH-1:0] act_codes;
    logic [NCH-1:0]   pwm_sel;
    logic [NCH-1:0]   wave;

    mo_ctrl_regs #(.NCH(NCH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .emr_wr    (emr_wr),
        .emr_wdata (emr_wdata),
        .pwm_wr    (pwm_wr),
        .pwm_wdata (pwm_wdata),
        .act_codes (act_codes),
        .pwm_sel   (pwm_sel)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        mo_level_unit u_lvl (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (match_hit[n]),
            .act   (mo_act_e'(act_codes[2*n +: 2])),
            .wr    (emr_wr),
            .wbit  (emr_wdata[n]),
            .level (em_level[n])
        );

        mo_pwm_cmp #(.TW(TW)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .tc_val (tc_val),
            .mval   (match_val[TW*n +: TW]),
            .wave   (wave[n])
        );

        // Output select: PWM compare or stored level.
        always_comb begin
            mat_out[n] = pwm_sel[n] ? wave[n] : em_level[n];
        end

        // R9: in match mode the pin shows the stored level
        a_r9_match_mode: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_sel[n] |-> mat_out[n] == em_level[n]);
    end

    // R1: outputs are zero right after reset
    a_r1_out_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> (em_level == '0 && mat_out == '0));

    // R10: with no hit and no write, no level moves
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit == '0 && !emr_wr |=> $stable(em_level));
endmodule

// File: tb/match_out_driver_test.sv
module match_out_driver_test;
    localparam int NCH = 4;
    localparam int TW  = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               emr_wr = 1'b0;
    logic [3*NCH-1:0]   emr_wdata = '0;
    logic               pwm_wr = 1'b0;
    logic [NCH-1:0]     pwm_wdata = '0;
    logic [NCH-1:0]     match_hit = '0;
    logic [TW-1:0]      tc_val = '0;
    logic [NCH*TW-1:0]  match_val = '0;
    logic [NCH-1:0]     em_level;
    logic [NCH-1:0]     mat_out;

    int checks = 0;
    int fails  = 0;

    // bench model of the requirements
    logic [NCH-1:0]   m_em  = '0;
    logic [2*NCH-1:0] m_act = '0;
    logic [NCH-1:0]   m_pwm = '0;
    logic [NCH-1:0]   m_cmp = '0;
    string            tag_em [NCH];

    match_out_driver #(.NCH(NCH), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .emr_wr(emr_wr), .emr_wdata(emr_wdata),
        .pwm_wr(pwm_wr), .pwm_wdata(pwm_wdata), .match_hit(match_hit),
        .tc_val(tc_val), .match_val(match_val), .em_level(em_level), .mat_out(mat_out)
    );

    always #5 clk = ~clk;

    function automatic logic exp_out(int n);
        return m_pwm[n] ? m_cmp[n] : m_em[n];
    endfunction

    task automatic chk(string req, int n, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch%0d actual=%b expected=%b", req, n, act, exp);
        end
    endtask

    // advance one clock, update the model, compare at the falling edge
    task automatic step(string ovr = "");
        logic [1:0] a;
        @(posedge clk);
        for (int n = 0; n < NCH; n++) begin
            a = m_act[2*n +: 2];
            if (match_hit[n] && a != 2'b00) begin
                tag_em[n] = (emr_wr) ? "R7" : (a == 2'b01) ? "R3" : (a == 2'b10) ? "R4" : "R5";
                m_em[n] = (a == 2'b01) ? 1'b0 : (a == 2'b10) ? 1'b1 : ~m_em[n];
            end else if (emr_wr) begin
                tag_em[n] = "R2";
                m_em[n] = emr_wdata[n];
            end else begin
                tag_em[n] = match_hit[n] ? "R6" : "R10";
            end
            m_cmp[n] = (tc_val >= match_val[TW*n +: TW]);
        end
        if (emr_wr) m_act = emr_wdata[NCH +: 2*NCH];
        if (pwm_wr) m_pwm = pwm_wdata;
        @(negedge clk);
        for (int n = 0; n < NCH; n++) begin
            chk((ovr != "") ? ovr : tag_em[n], n, em_level[n], m_em[n]);
            chk((ovr != "") ? ovr : (m_pwm[n] ? "R8" : "R9"), n, mat_out[n], exp_out(n));
        end
    endtask

    task automatic idle();
        emr_wr = 1'b0; pwm_wr = 1'b0; match_hit = '0;
    endtask

    initial begin
        #1500000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int n = 0; n < NCH; n++) begin
            chk("R1", n, em_level[n], 1'b0);
            chk("R1", n, mat_out[n], 1'b0);
        end
        rst_n = 1'b1;
        step("R1");

        // R7: ch0 set to clear, level 1 by write, then write+hit with new code
        emr_wr = 1'b1; emr_wdata = {8'b00_00_00_01, 4'b0001};
        step("R2");
        emr_wdata = {8'b00_00_00_10, 4'b0001}; match_hit = 4'b0001;
        step("R7");
        emr_wr = 1'b0;
        step("R7");   // new set code now acts
        // R5: back-to-back toggles on ch2, ch1/ch3 must stay (R10)
        emr_wr = 1'b1; emr_wdata = {8'b00_11_00_00, 4'b0000}; match_hit = '0;
        step("R2");
        emr_wr = 1'b0; match_hit = 4'b0100;
        step("R5"); step("R5"); step("R5");
        match_hit = 4'b1010;
        step("R10");
        // R8: ch1 PWM at match value 7, count 6/7/8
        idle(); match_val[TW*1 +: TW] = 32'd7;
        pwm_wr = 1'b1; pwm_wdata = 4'b0010; tc_val = 32'd6;
        step("R8");
        pwm_wr = 1'b0;
        step("R8");
        tc_val = 32'd7; step("R8");
        tc_val = 32'd8; step("R8");
        // R9: ch1 set action while in PWM, count below match
        emr_wr = 1'b1; emr_wdata = {8'b00_00_10_00, 4'b0000}; tc_val = 32'd0;
        step("R9");
        emr_wr = 1'b0; match_hit = 4'b0010;
        step("R9");
        idle(); pwm_wr = 1'b1; pwm_wdata = 4'b0000;
        step("R9");
        idle();
        step("R9");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            emr_wr    = ($urandom_range(7) == 0);
            emr_wdata = 12'($urandom);
            pwm_wr    = ($urandom_range(15) == 0);
            pwm_wdata = 4'($urandom);
            match_hit = 4'($urandom) & 4'($urandom);
            tc_val    = 32'($urandom_range(15));
            for (int n = 0; n < NCH; n++)
                if ($urandom_range(31) == 0) match_val[TW*n +: TW] = 32'($urandom_range(15));
            step();
        end
        idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule